// File: doc/BRIEF.md
# Stretchable Bus Cycle Sequencer

This block is the processor-side timing generator for a multiplexed system bus. Each accepted request produces one bus cycle made of numbered clock phases T0 to T7. The sequencer drives the address latch enable, the strobe, the buffer control and the stretch control outputs. It also gives a phase indicator, a DMA acknowledge status and a pulse that marks when read data is captured into its internal register.

A cycle is either short or stretched. A short cycle uses T0 to T3 only, which is four clocks. A stretched cycle continues after T3 into T4, stays in T4 for an odd number of clocks until the continue handshake has been seen, and then finishes with T5, T6 and T7. Whether a cycle is stretched depends on its type and on the cache miss and DMA request inputs sampled during T3.

External logic uses the strobes to latch addresses, enable data buffers and gate write pulses. It holds a cycle open for as long as needed by withholding continue. All logic is clocked on the rising edge of one clock.

Top module: `busCycleSeq`

## Requirements
- R1: While `rst` is high and in the first clock after it falls, `active` is 0, `phase` is 0, every strobe output, `capture` and `dmaAck` are 0, and `rdData` is 0.
- R2: The cycle type encoding is 0 internal (non-I/O), 1 cacheable read, 2 uncached read and 3 write. When idle with `reqValid` high, the next clock is T0 of a new cycle of type `reqType`. `phase` shows the T number as 0..7 and `active` is high during a cycle. `ale` is high exactly in T0.
- R3: `strobe` is high from T1 through the last phase of the cycle, and low in T0 and when idle.
- R4: A type 0 or type 1 cycle with `miss` and `dmaReq` both low during T3 ends after T3, so it lasts 4 clocks.
- R5: A cycle of type 2 or 3, or a type 0 or 1 cycle with `miss` or `dmaReq` high during T3, goes from T3 to T4. `miss` and `dmaReq` have no effect in any other phase.
- R6: T4 is left for T5 only at the end of a T4 clock whose position in the run of T4 clocks is odd, and only if `cont` has been high in that clock or in an earlier T4 clock of the cycle. The run length is therefore the smallest odd number that is at least the position of the first `cont`. Without `cont` the cycle waits in T4 indefinitely, and `cont` outside T4 is ignored.
- R7: `stretchCtl` is high in every T4 clock after the first one and in T5, T6 and T7. It is low elsewhere.
- R8: `bufCtl` is high in T2, T3, T5, T6 and T7, and low in T0, T1, T4 and when idle.
- R9: In a short read (type 1), `capture` is high during T3 without regard to `dataValid`, and `rdData` takes `busData` at the end of T3.
- R10: In a stretched read (type 1 or 2), `capture` is high in a T5, T6 or T7 clock in which `dataValid` is high, and `rdData` takes `busData` at the end of that clock. `dataValid` is ignored in T0 to T4, in non-read cycles and when idle.
- R11: `dmaAck` is high from T4 through T7 of a cycle in which `dmaReq` was high during T3, and low otherwise.
- R12: If `reqValid` is high in the last phase of a cycle, the next clock is T0 of the next cycle with no idle clock. A `rst` pulse in the middle of a cycle returns the block to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request for a new bus cycle |
| reqType | input | 2 | Cycle type of the request |
| cont | input | 1 | Continue handshake for stretched cycles |
| dataValid | input | 1 | Read data on busData is valid (stretched part) |
| miss | input | 1 | Cache miss, forces stretch when sampled in T3 |
| dmaReq | input | 1 | DMA request, forces stretch when sampled in T3 |
| busData | input | DATA_W | Read data from the bus |
| active | output | 1 | A bus cycle is in progress |
| phase | output | 3 | Current phase number T0..T7 |
| ale | output | 1 | Address latch enable |
| strobe | output | 1 | Cycle strobe |
| bufCtl | output | 1 | Buffer enable, high while the data lines are free |
| stretchCtl | output | 1 | Stretch control |
| dmaAck | output | 1 | DMA request honoured in this cycle |
| capture | output | 1 | Read data captured in this clock |
| rdData | output | DATA_W | Last captured read data |

## Verification
A cacheable read is both a candidate for the end-of-T3 short capture and a candidate for stretching by a DMA request or a miss sampled in the same T3 clock. Both decisions fall in that one clock. The bench provokes this by raising `dmaReq` or `miss` exactly in T3 of type 1 cycles, while `dataValid` toggles at random outside the stretched part. A behavioural reference model judges every clock and requires that the capture pulse moves to the qualified T5..T7 window, that `dmaAck` rises in T4, and that `rdData` keeps its old value through T3. A `cont` pulse that lands on an even T4 position is used to check that it is remembered until the run of T4 clocks becomes odd.

// File: rtl/busCycleSeqPkg.sv
package busCycleSeqPkg;
  localparam int PHASE_W = 3;
  localparam int TYPE_W = 2;

  typedef enum logic [TYPE_W-1:0] {
    CYC_INTERNAL    = 2'd0,
    CYC_CACHED_RD   = 2'd1,
    CYC_UNCACHED_RD = 2'd2,
    CYC_WRITE       = 2'd3
  } cycType_e;

  localparam logic [PHASE_W-1:0] PH_T0 = 3'd0;
  localparam logic [PHASE_W-1:0] PH_T2 = 3'd2;
  localparam logic [PHASE_W-1:0] PH_T3 = 3'd3;
  localparam logic [PHASE_W-1:0] PH_T4 = 3'd4;
  localparam logic [PHASE_W-1:0] PH_T5 = 3'd5;
  localparam logic [PHASE_W-1:0] PH_T7 = 3'd7;

  typedef struct packed {
    logic capture;
  } dpStrobes_t;
endpackage

// File: rtl/busCycleSeqCtrl.sv
module busCycleSeqCtrl
  import busCycleSeqPkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               reqValid,
  input  logic [TYPE_W-1:0]  reqType,
  input  logic               cont,
  input  logic               dataValid,
  input  logic               miss,
  input  logic               dmaReq,
  output logic               active,
  output logic [PHASE_W-1:0] phase,
  output logic               ale,
  output logic               strobe,
  output logic               bufCtl,
  output logic               stretchCtl,
  output logic               dmaAck,
  output dpStrobes_t         dpStb
);
  cycType_e cycType;
  logic pastFirstT4;
  logic t4Odd;
  logic contSeen;
  logic dmaHit;

  logic isRead;
  logic wantStretch;
  logic lastPhase;
  logic t4Exit;
  logic inTail;

  assign isRead      = (cycType == CYC_CACHED_RD) || (cycType == CYC_UNCACHED_RD);
  assign wantStretch = cycType[1] || miss || dmaReq;
  assign inTail      = active && (phase >= PH_T5);
  assign lastPhase   = active && ((phase == PH_T7) || ((phase == PH_T3) && !wantStretch));
  assign t4Exit      = (phase == PH_T4) && !t4Odd && (cont || contSeen);

  always_ff @(posedge clk) begin
    if (rst) begin
      active      <= 1'b0;
      phase       <= PH_T0;
      cycType     <= CYC_INTERNAL;
      pastFirstT4 <= 1'b0;
      t4Odd       <= 1'b0;
      contSeen    <= 1'b0;
      dmaHit      <= 1'b0;
    end else if (!active || lastPhase) begin
      phase  <= PH_T0;
      dmaHit <= 1'b0;
      if (reqValid) begin
        active  <= 1'b1;
        cycType <= cycType_e'(reqType);
      end else begin
        active <= 1'b0;
      end
    end else begin
      unique case (phase)
        PH_T3: begin
          phase       <= PH_T4;
          dmaHit      <= dmaReq;
          pastFirstT4 <= 1'b0;
          t4Odd       <= 1'b0;
          contSeen    <= 1'b0;
        end
        PH_T4: begin
          if (t4Exit) begin
            phase <= PH_T5;
          end else begin
            pastFirstT4 <= 1'b1;
            t4Odd       <= ~t4Odd;
            contSeen    <= contSeen | cont;
          end
        end
        default: phase <= phase + 3'd1;
      endcase
    end
  end

  always_comb begin
    ale        = active && (phase == PH_T0);
    strobe     = active && (phase != PH_T0);
    bufCtl     = active && ((phase == PH_T2) || (phase == PH_T3) || (phase >= PH_T5));
    stretchCtl = inTail || (active && (phase == PH_T4) && pastFirstT4);
    dmaAck     = active && (phase >= PH_T4) && dmaHit;
    dpStb.capture = active && isRead &&
                    (((phase == PH_T3) && !wantStretch) ||
                     (dataValid && bufCtl && stretchCtl));
  end
endmodule

// File: rtl/busCycleSeqData.sv
module busCycleSeqData
  import busCycleSeqPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobes_t        dpStb,
  input  logic [DATA_W-1:0] busData,
  output logic [DATA_W-1:0] rdData
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else if (dpStb.capture) begin
      rdData <= busData;
    end
  end
endmodule

// File: rtl/busCycleSeq.sv
module busCycleSeq
  import busCycleSeqPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [1:0]        reqType,
  input  logic              cont,
  input  logic              dataValid,
  input  logic              miss,
  input  logic              dmaReq,
  input  logic [DATA_W-1:0] busData,
  output logic              active,
  output logic [2:0]        phase,
  output logic              ale,
  output logic              strobe,
  output logic              bufCtl,
  output logic              stretchCtl,
  output logic              dmaAck,
  output logic              capture,
  output logic [DATA_W-1:0] rdData
);
  dpStrobes_t dpStb;

  busCycleSeqCtrl uCtrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqType(reqType),
    .cont(cont), .dataValid(dataValid), .miss(miss), .dmaReq(dmaReq),
    .active(active), .phase(phase), .ale(ale), .strobe(strobe),
    .bufCtl(bufCtl), .stretchCtl(stretchCtl), .dmaAck(dmaAck),
    .dpStb(dpStb)
  );

  busCycleSeqData #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rst(rst), .dpStb(dpStb), .busData(busData), .rdData(rdData)
  );

  assign capture = dpStb.capture;
endmodule

// File: rtl/busCycleSeqChecker.sv
module busCycleSeqChecker (
  input logic       clk,
  input logic       rst,
  input logic       cont,
  input logic       active,
  input logic [2:0] phase,
  input logic       ale,
  input logic       strobe,
  input logic       bufCtl,
  input logic       stretchCtl,
  input logic       dmaAck,
  input logic       capture
);
  p_ale_single_r2: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

  p_strobe_after_ale_r3: assert property (@(posedge clk) disable iff (rst)
    ale |=> strobe);

  p_first_t4_waits_r6: assert property (@(posedge clk) disable iff (rst)
    (active && phase == 3'd4 && !stretchCtl && !cont) |=> (phase == 3'd4));

  p_sctl_after_t4_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(stretchCtl) |-> ($past(phase) == 3'd4));

  p_buf_gap_r8: assert property (@(posedge clk) disable iff (rst)
    (bufCtl && phase == 3'd3) |=> !bufCtl);

  p_short_capture_ends_r9: assert property (@(posedge clk) disable iff (rst)
    (capture && phase == 3'd3) |=> (phase == 3'd0));

  p_dma_in_stretch_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(dmaAck) |-> ($past(phase) == 3'd3));
endmodule

bind busCycleSeq busCycleSeqChecker uChk (
  .clk(clk), .rst(rst), .cont(cont), .active(active), .phase(phase),
  .ale(ale), .strobe(strobe), .bufCtl(bufCtl), .stretchCtl(stretchCtl),
  .dmaAck(dmaAck), .capture(capture)
);

// File: tb/busCycleSeq_test.sv
module busCycleSeq_test;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int NSCN = 14;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0;
  logic [1:0] reqType = 2'd0;
  logic cont = 1'b0, dataValid = 1'b0, miss = 1'b0, dmaReq = 1'b0;
  logic [DATA_W-1:0] busData = '0;
  logic active, ale, strobe, bufCtl, stretchCtl, dmaAck, capture;
  logic [2:0] phase;
  logic [DATA_W-1:0] rdData;

  busCycleSeq #(.DATA_W(DATA_W)) uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqType(reqType),
    .cont(cont), .dataValid(dataValid), .miss(miss), .dmaReq(dmaReq),
    .busData(busData), .active(active), .phase(phase), .ale(ale),
    .strobe(strobe), .bufCtl(bufCtl), .stretchCtl(stretchCtl),
    .dmaAck(dmaAck), .capture(capture), .rdData(rdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // scenario table: type, miss in T3, dma in T3, T4 position of cont pulse,
  // phase of dataValid in tail (0 none), back-to-back start
  int sType[NSCN], sMiss[NSCN], sDma[NSCN], sCont[NSCN], sDv[NSCN], sB2b[NSCN];

  int checks = 0, fails = 0, cycCount = 0, scnIdx = 0;
  bit started = 0;

  // behavioural reference model state
  int mActive = 0, mPh = 0, mType = 0, mPastFirst = 0, mOdd = 0;
  int mContSeen = 0, mDma = 0, mT4Idx = 0, mScn = 0;
  logic [DATA_W-1:0] mData = '0;
  bit mEnding;
  bit mIsRd;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycCount);
    end
  endtask

  task automatic finishTest();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  function automatic bit wantStretchM();
    return (mType >= 2) || miss || dmaReq;
  endfunction

  always @(posedge clk) begin
    cycCount++;
    if (rst) begin
      mActive = 0; mPh = 0; mDma = 0; mData = '0;
    end else begin
      mEnding = 0;
      mIsRd = (mType == 1) || (mType == 2);
      if (mActive != 0) begin
        case (mPh)
          3: if (wantStretchM()) begin
               mPh = 4; mDma = dmaReq; mPastFirst = 0; mOdd = 0;
               mContSeen = 0; mT4Idx = 1;
             end else begin
               if (mIsRd) mData = busData;
               mEnding = 1;
             end
          4: if (mOdd == 0 && (cont || mContSeen != 0)) mPh = 5;
             else begin
               if (cont) mContSeen = 1;
               mOdd = 1 - mOdd; mPastFirst = 1; mT4Idx++;
             end
          5, 6: begin if (mIsRd && dataValid) mData = busData; mPh++; end
          7: begin if (mIsRd && dataValid) mData = busData; mEnding = 1; end
          default: mPh++;
        endcase
      end
      if (mActive == 0 || mEnding) begin
        mPh = 0; mDma = 0;
        if (reqValid) begin
          mActive = 1; mType = int'(reqType); mScn = scnIdx; scnIdx++;
        end else begin
          mActive = 0;
        end
      end
    end
  end

  // compare, then drive the inputs for the next clock
  always @(negedge clk) begin
    bit a, lastPh, capExp;
    int s;
    if (started) begin
      a = (mActive != 0);
      check("R2 active", 32'(active), 32'(a));
      check("R2 R4 R5 R6 R12 phase", 32'(phase), a ? mPh : 0);
      check("R2 ale", 32'(ale), 32'(a && mPh == 0));
      check("R3 strobe", 32'(strobe), 32'(a && mPh != 0));
      check("R8 bufCtl", 32'(bufCtl), 32'(a && (mPh == 2 || mPh == 3 || mPh >= 5)));
      check("R7 stretchCtl", 32'(stretchCtl), 32'(a && ((mPh == 4 && mPastFirst != 0) || mPh >= 5)));
      check("R11 dmaAck", 32'(dmaAck), 32'(a && mPh >= 4 && mDma != 0));
      capExp = a && (mType == 1 || mType == 2) &&
               ((mPh == 3 && !wantStretchM()) || (mPh >= 5 && dataValid));
      check("R9 R10 capture", 32'(capture), 32'(capExp));
      check("R9 R10 rdData", 32'(rdData), 32'(mData));
    end
    s = (mScn < NSCN) ? mScn : NSCN - 1;
    busData = DATA_W'($urandom);
    if (mActive != 0 && mPh == 3) begin
      miss = sMiss[s][0]; dmaReq = sDma[s][0];
    end else begin
      miss = 1'($urandom); dmaReq = 1'($urandom);
    end
    if (mActive != 0 && mPh == 4) cont = (mT4Idx == sCont[s]);
    else cont = 1'($urandom);
    if (mActive != 0 && mPh >= 5) dataValid = (mPh == sDv[s]);
    else dataValid = 1'($urandom);
    lastPh = (mActive != 0) && (mPh == 7 || (mPh == 3 && !wantStretchM()));
    if (scnIdx < NSCN && !rst) begin
      reqValid = (mActive == 0) || (lastPh && sB2b[scnIdx] != 0);
      reqType = 2'(sType[scnIdx]);
    end else begin
      reqValid = 1'b0;
      reqType = 2'($urandom);
    end
  end

  always @(posedge clk) begin
    if (cycCount > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog expired, actual=running expected=done");
      finishTest();
    end
  end

  task automatic setScn(input int i, input int t, input int m, input int d,
                        input int c, input int v, input int b);
    sType[i] = t; sMiss[i] = m; sDma[i] = d; sCont[i] = c; sDv[i] = v; sB2b[i] = b;
  endtask

  initial begin
    setScn(0, 0, 0, 0, 1, 0, 0);   // R4 internal short
    setScn(1, 1, 0, 0, 1, 0, 0);   // R9 short read
    setScn(2, 1, 1, 0, 1, 5, 0);   // R5 miss stretches, R10
    setScn(3, 2, 0, 0, 2, 6, 0);   // R6 cont on even position -> 3 T4
    setScn(4, 3, 0, 0, 4, 5, 0);   // R6 five T4, write ignores dataValid
    setScn(5, 0, 0, 1, 1, 0, 0);   // R11 DMA stretches internal
    setScn(6, 1, 0, 1, 3, 7, 0);   // R11 R10 DMA vs short capture
    setScn(7, 1, 0, 0, 1, 0, 1);   // R12 back to back
    setScn(8, 2, 0, 0, 1, 5, 1);   // R12
    setScn(9, 3, 0, 0, 1, 0, 1);   // R12
    setScn(10, 0, 0, 0, 1, 0, 1);  // R12 short after stretched
    setScn(11, 2, 0, 0, 30, 0, 0); // R6 long wait, no dataValid
    setScn(12, 1, 0, 0, 1, 0, 0);  // R9
    setScn(13, 2, 0, 0, 60, 0, 0); // R12 reset mid-cycle
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 reset active", 32'(active), 0);
    check("R1 reset strobes", 32'({ale, strobe, bufCtl, stretchCtl, dmaAck, capture}), 0);
    check("R1 reset rdData", 32'(rdData), 0);
    started = 1;
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle after reset phase", 32'(phase), 0);
    wait (scnIdx == NSCN && mActive != 0 && mPh == 4 && mT4Idx == 5);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R12 reset mid-cycle active", 32'(active), 0);
    check("R12 reset mid-cycle strobe", 32'(strobe), 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    finishTest();
  end
endmodule